// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows the stage of each control transfer on endpoint 0 of a USB device controller. It is fed with events: a decoded SETUP packet (its direction bit and its requested data length), IN packet completions, a pulse marking that the final IN packet of the data stage has been queued, OUT packet completions with their byte count, a stall request from firmware, and the completion of the status handshake. From these it keeps a registered stage value, drives the stall handshake enable, and raises a request for the status-stage acknowledgment.

After the final IN packet is queued, the sequencer waits in a dedicated stage until that packet has actually completed, and only then asks for the status handshake. An OUT data stage ends on a short packet or once the requested length has been received. A stall persists until the host sends a new SETUP. A delay input lets firmware hold back the status acknowledgment while it finishes a request. A six-byte response buffer holds small replies (a two-byte status word, a six-byte latency block).

Top module: `ep0_stage_seq`

## Requirements
- R1: Stages are encoded SETUP=1, TX=2, RX=3, TX_END=4, STALL=5 on `stage`; after reset `stage` is 1, `stall_hs` is 0 and `status_ack_req` is 0.
- R2: One cycle after a SETUP with a nonzero length, `stage` is 2 if `setup_dir_in` is 1, or 3 if it is 0.
- R3: One cycle after a SETUP with zero length, `stage` is 1 and a status acknowledgment is pending.
- R4: In TX, `in_done` alone keeps the stage at 2; `in_last_queued` moves it to 4; in stage 4 the stage holds until `in_done`, which returns it to 1 with a status acknowledgment pending.
- R5: In RX, an OUT completion with `out_bytes` below `MAX_PKT` ends the data stage: stage 1 with a status acknowledgment pending.
- R6: In RX, full-size OUT packets keep stage 3 until the total received reaches the SETUP length, which ends the data stage as in R5.
- R7: A `stall_req` without a SETUP in the same cycle puts the stage at 5 with `stall_hs` 1 and drops any pending status acknowledgment.
- R8: In STALL, every event except a SETUP is ignored; a SETUP leaves it by the rules of R2 and R3 and clears `stall_hs`.
- R9: A SETUP and a `stall_req` in the same cycle: the SETUP wins.
- R10: While `delay_status` is 1, `status_ack_req` is 0 and `status_done` does not clear the pending acknowledgment; once released the request shows, and `status_done` then clears it.
- R11: The response buffer stores bytes at indices 0 to 5, read back combinationally on `rsp_rd_data`; writes to indices 6 and 7 are ignored and reads there return 0.
- R12: Data events that do not belong to the current stage (OUT completions in TX, IN events in RX or SETUP) leave the stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_valid | input | 1 | SETUP packet received this cycle |
| setup_dir_in | input | 1 | Direction of the SETUP: 1 device-to-host |
| setup_len | input | LEN_W | Requested data-stage length in bytes |
| in_last_queued | input | 1 | Final IN packet of the data stage queued |
| in_done | input | 1 | An IN packet completed |
| out_done | input | 1 | An OUT packet completed |
| out_bytes | input | PKT_W | Byte count of the completed OUT packet |
| stall_req | input | 1 | Firmware asks to stall endpoint 0 |
| status_done | input | 1 | Status handshake completed |
| delay_status | input | 1 | Hold back the status acknowledgment |
| rsp_wr_en | input | 1 | Write a response byte |
| rsp_wr_idx | input | RSP_IDX_W | Response byte write index |
| rsp_wr_data | input | 8 | Response byte to write |
| rsp_rd_idx | input | RSP_IDX_W | Response byte read index |
| rsp_rd_data | output | 8 | Response byte at the read index |
| stage | output | 3 | Current stage code |
| stall_hs | output | 1 | Answer with a stall handshake |
| status_ack_req | output | 1 | Request to acknowledge the status stage |

## Verification
The stage machine is driven with IN transfers, OUT transfers ended by a short packet and by an exact-length sequence of full packets, and zero-length requests; comparing the two OUT endings separates the short-packet rule from the length count. Stalls are entered from the data stages and from an idle stage with a pending acknowledgment, then hit with stray events, which tells a sticky stall from one that leaks. Simultaneous SETUP and stall, stray IN and OUT events in the wrong stage, and a delayed status with an early `status_done` distinguish priority errors from simple transition errors. The response buffer is filled, then written and read past its six bytes.

// File: rtl/ep0_seq_pkg.sv
// Shared definitions for the endpoint 0 stage sequencer.
// Assumes the stage codes are observed by software, so they are fixed.
package ep0_seq_pkg;
    typedef enum logic [2:0] {
        STG_SETUP  = 3'd1,
        STG_TX     = 3'd2,
        STG_RX     = 3'd3,
        STG_TX_END = 3'd4,
        STG_STALL  = 3'd5
    } ep0_stage_e;
endpackage

// File: rtl/ep0_out_tracker.sv
// Counts the bytes still expected in an OUT data stage and flags the
// packet that ends it (short packet or requested length reached).
// Assumes LEN_W >= PKT_W and that rx_active is 1 only in the RX stage.
module ep0_out_tracker #(
    parameter int LEN_W   = 16,
    parameter int PKT_W   = 11,
    parameter int MAX_PKT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             rx_active,
    input  logic             out_done,
    input  logic [PKT_W-1:0] out_bytes,
    output logic             rx_end
);
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] bytes_ext;
    logic             is_short;
    logic             reach;

    // Compare the packet against the packet limit and the remaining count
    always_comb begin
        bytes_ext = LEN_W'(out_bytes);
        is_short  = out_bytes < PKT_W'(MAX_PKT);
        reach     = bytes_ext >= remain_q;
        rx_end    = rx_active && out_done && (is_short || reach);
    end

    // Hold the number of bytes still to be received
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_len;
        end else if (rx_active && out_done) begin
            remain_q <= reach ? '0 : remain_q - bytes_ext;
        end
    end
endmodule

// File: rtl/ep0_stage_fsm.sv
// Stage register for endpoint 0 control transfers.
// A SETUP has priority over a stall request, which has priority over
// data events. Assumes rx_end is already qualified by the RX stage.
module ep0_stage_fsm
    import ep0_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_valid,
    input  logic       setup_dir_in,
    input  logic       setup_len_nz,
    input  logic       stall_req,
    input  logic       in_last_queued,
    input  logic       in_done,
    input  logic       rx_end,
    output ep0_stage_e stage_q,
    output logic       data_end
);
    ep0_stage_e stage_d;

    // Next stage from the current stage and this cycle's events
    always_comb begin
        stage_d = stage_q;
        if (setup_valid) begin
            if (!setup_len_nz) stage_d = STG_SETUP;
            else if (setup_dir_in) stage_d = STG_TX;
            else stage_d = STG_RX;
        end else if (stall_req) begin
            stage_d = STG_STALL;
        end else begin
            case (stage_q)
                STG_TX:     if (in_last_queued) stage_d = STG_TX_END;
                STG_TX_END: if (in_done) stage_d = STG_SETUP;
                STG_RX:     if (rx_end) stage_d = STG_SETUP;
                default:    stage_d = stage_q;
            endcase
        end
    end

    // Pulse when a data stage finishes normally
    always_comb begin
        data_end = !setup_valid && !stall_req &&
                   (((stage_q == STG_TX_END) && in_done) || rx_end);
    end

    // Stage register
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= STG_SETUP;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/ep0_status_gate.sv
// Keeps the pending status acknowledgment and masks it while firmware
// asks for a delay. Setting wins over every clearing source.
module ep0_status_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pend,
    input  logic drop_pend,
    input  logic status_done,
    input  logic delay_status,
    output logic ack_req
);
    logic pend_q;

    // Track whether a status acknowledgment is owed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_pend) begin
            pend_q <= 1'b1;
        end else if (drop_pend) begin
            pend_q <= 1'b0;
        end else if (status_done && !delay_status) begin
            pend_q <= 1'b0;
        end
    end

    // Show the request only when not delayed
    always_comb ack_req = pend_q && !delay_status;
endmodule

// File: rtl/ep0_resp_buf.sv
// Small byte buffer for endpoint 0 replies. Out-of-range writes are
// dropped and out-of-range reads return zero.
module ep0_resp_buf #(
    parameter int DEPTH = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        // Store one byte when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[g] <= 8'h00;
            else if (wr_en && (wr_idx == IDX_W'(g))) mem_q[g] <= wr_data;
        end
    end

    // Select the addressed byte, zero beyond the buffer
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = mem_q[i];
        end
    end
endmodule

// File: rtl/ep0_stage_seq.sv
// Top of the endpoint 0 stage sequencer: stage register, OUT length
// tracker, status acknowledgment gate and reply buffer.
// Assumes event inputs are single-cycle pulses and at most one data
// event class is meaningful per stage.
module ep0_stage_seq
    import ep0_seq_pkg::*;
#(
    parameter int  LEN_W     = 16,
    parameter int  PKT_W     = 11,
    parameter int  MAX_PKT   = 64,
    parameter int  RSP_DEPTH = 6,
    localparam int RSP_IDX_W = $clog2(RSP_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_valid,
    input  logic                 setup_dir_in,
    input  logic [LEN_W-1:0]     setup_len,
    input  logic                 in_last_queued,
    input  logic                 in_done,
    input  logic                 out_done,
    input  logic [PKT_W-1:0]     out_bytes,
    input  logic                 stall_req,
    input  logic                 status_done,
    input  logic                 delay_status,
    input  logic                 rsp_wr_en,
    input  logic [RSP_IDX_W-1:0] rsp_wr_idx,
    input  logic [7:0]           rsp_wr_data,
    input  logic [RSP_IDX_W-1:0] rsp_rd_idx,
    output logic [7:0]           rsp_rd_data,
    output logic [2:0]           stage,
    output logic                 stall_hs,
    output logic                 status_ack_req
);
    ep0_stage_e cur_stage;
    logic       len_nz;
    logic       rx_end;
    logic       data_end;
    logic       set_pend;
    logic       drop_pend;

    // Decode setup length and status gate controls
    always_comb begin
        len_nz    = |setup_len;
        set_pend  = (setup_valid && !len_nz) || data_end;
        drop_pend = setup_valid || stall_req;
    end

    ep0_out_tracker #(
        .LEN_W  (LEN_W),
        .PKT_W  (PKT_W),
        .MAX_PKT(MAX_PKT)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (setup_valid),
        .load_len (setup_len),
        .rx_active(cur_stage == STG_RX),
        .out_done (out_done),
        .out_bytes(out_bytes),
        .rx_end   (rx_end)
    );

    ep0_stage_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .setup_valid   (setup_valid),
        .setup_dir_in  (setup_dir_in),
        .setup_len_nz  (len_nz),
        .stall_req     (stall_req),
        .in_last_queued(in_last_queued),
        .in_done       (in_done),
        .rx_end        (rx_end),
        .stage_q       (cur_stage),
        .data_end      (data_end)
    );

    ep0_status_gate u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_pend    (set_pend),
        .drop_pend   (drop_pend),
        .status_done (status_done),
        .delay_status(delay_status),
        .ack_req     (status_ack_req)
    );

    ep0_resp_buf #(
        .DEPTH(RSP_DEPTH),
        .IDX_W(RSP_IDX_W)
    ) u_rsp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rsp_wr_en),
        .wr_idx (rsp_wr_idx),
        .wr_data(rsp_wr_data),
        .rd_idx (rsp_rd_idx),
        .rd_data(rsp_rd_data)
    );

    // Drive stage code and stall handshake from the stage register
    always_comb begin
        stage    = cur_stage;
        stall_hs = (cur_stage == STG_STALL);
    end
endmodule

// File: rtl/ep0_stage_seq_chk.sv
// Property checker for the endpoint 0 stage sequencer, bound to the top.
module ep0_stage_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             setup_valid,
    input logic             setup_dir_in,
    input logic [LEN_W-1:0] setup_len,
    input logic             stall_req,
    input logic             in_done,
    input logic             delay_status,
    input logic [2:0]       stage,
    input logic             stall_hs,
    input logic             status_ack_req
);
    AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (stage >= 3'd1) && (stage <= 3'd5)); // R1
    AST_SETUP_TO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && (setup_len != '0) && setup_dir_in |=> stage == 3'd2); // R2
    AST_SETUP_TO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && (setup_len != '0) && !setup_dir_in |=> stage == 3'd3); // R2
    AST_ZERO_LEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && (setup_len == '0) |=> (stage == 3'd1) && (status_ack_req || delay_status)); // R3
    AST_TXEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd4) && !in_done && !setup_valid && !stall_req |=> stage == 3'd4); // R4
    AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req && !setup_valid |=> (stage == 3'd5) && stall_hs && !status_ack_req); // R7
    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'd5) && !setup_valid |=> stage == 3'd5); // R8
    AST_DELAY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        delay_status |-> !status_ack_req); // R10
endmodule

bind ep0_stage_seq ep0_stage_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .setup_valid   (setup_valid),
    .setup_dir_in  (setup_dir_in),
    .setup_len     (setup_len),
    .stall_req     (stall_req),
    .in_done       (in_done),
    .delay_status  (delay_status),
    .stage         (stage),
    .stall_hs      (stall_hs),
    .status_ack_req(status_ack_req)
);

// File: tb/tb_ep0_stage_seq.sv
// Directed bench for the endpoint 0 stage sequencer.
module tb_ep0_stage_seq;
    localparam int LEN_W = 16;
    localparam int PKT_W = 11;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             setup_valid = 1'b0;
    logic             setup_dir_in = 1'b0;
    logic [LEN_W-1:0] setup_len = '0;
    logic             in_last_queued = 1'b0;
    logic             in_done = 1'b0;
    logic             out_done = 1'b0;
    logic [PKT_W-1:0] out_bytes = '0;
    logic             stall_req = 1'b0;
    logic             status_done = 1'b0;
    logic             delay_status = 1'b0;
    logic             rsp_wr_en = 1'b0;
    logic [IDX_W-1:0] rsp_wr_idx = '0;
    logic [7:0]       rsp_wr_data = '0;
    logic [IDX_W-1:0] rsp_rd_idx = '0;
    logic [7:0]       rsp_rd_data;
    logic [2:0]       stage;
    logic             stall_hs;
    logic             status_ack_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    ep0_stage_seq dut (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_dir_in(setup_dir_in), .setup_len(setup_len),
        .in_last_queued(in_last_queued), .in_done(in_done),
        .out_done(out_done), .out_bytes(out_bytes),
        .stall_req(stall_req), .status_done(status_done), .delay_status(delay_status),
        .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx), .rsp_wr_data(rsp_wr_data),
        .rsp_rd_idx(rsp_rd_idx), .rsp_rd_data(rsp_rd_data),
        .stage(stage), .stall_hs(stall_hs), .status_ack_req(status_ack_req)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input int st, input int hs, input int ack, input string req);
        check(int'(stage), st, req, "stage");
        check(int'(stall_hs), hs, req, "stall_hs");
        check(int'(status_ack_req), ack, req, "status_ack_req");
    endtask

    // Each event task drives for one clock and returns at the next falling edge
    task automatic ev_setup(input bit dir_in, input int len, input bit with_stall);
        @(negedge clk);
        setup_valid = 1'b1; setup_dir_in = dir_in; setup_len = LEN_W'(len);
        stall_req = with_stall;
        @(negedge clk);
        setup_valid = 1'b0; stall_req = 1'b0;
    endtask

    task automatic ev_in(input bit last_q, input bit done);
        @(negedge clk);
        in_last_queued = last_q; in_done = done;
        @(negedge clk);
        in_last_queued = 1'b0; in_done = 1'b0;
    endtask

    task automatic ev_out(input int nbytes);
        @(negedge clk);
        out_done = 1'b1; out_bytes = PKT_W'(nbytes);
        @(negedge clk);
        out_done = 1'b0;
    endtask

    task automatic ev_stall();
        @(negedge clk); stall_req = 1'b1;
        @(negedge clk); stall_req = 1'b0;
    endtask

    task automatic ev_status();
        @(negedge clk); status_done = 1'b1;
        @(negedge clk); status_done = 1'b0;
    endtask

    task automatic t_reset();
        chk_state(1, 0, 0, "R1");
        rsp_rd_idx = 3'd0; #1;
        check(int'(rsp_rd_data), 0, "R11", "buffer after reset");
    endtask

    task automatic t_in_transfer();
        ev_setup(1'b1, 18, 1'b0);
        chk_state(2, 0, 0, "R2");
        ev_in(1'b0, 1'b1);
        chk_state(2, 0, 0, "R4");
        ev_out(5);
        chk_state(2, 0, 0, "R12");
        ev_in(1'b1, 1'b0);
        chk_state(4, 0, 0, "R4");
        repeat (3) @(negedge clk);
        chk_state(4, 0, 0, "R4");
        ev_in(1'b0, 1'b1);
        chk_state(1, 0, 1, "R4");
        ev_status();
        chk_state(1, 0, 0, "R10");
    endtask

    task automatic t_out_short();
        ev_setup(1'b0, 200, 1'b0);
        chk_state(3, 0, 0, "R2");
        ev_in(1'b1, 1'b1);
        chk_state(3, 0, 0, "R12");
        ev_out(64);
        chk_state(3, 0, 0, "R6");
        ev_out(10);
        chk_state(1, 0, 1, "R5");
        ev_status();
        chk_state(1, 0, 0, "R10");
    endtask

    task automatic t_out_exact();
        ev_setup(1'b0, 128, 1'b0);
        ev_out(64);
        chk_state(3, 0, 0, "R6");
        ev_out(64);
        chk_state(1, 0, 1, "R6");
        ev_status();
    endtask

    task automatic t_zero_len();
        ev_setup(1'b1, 0, 1'b0);
        chk_state(1, 0, 1, "R3");
        ev_in(1'b1, 1'b0);
        chk_state(1, 0, 1, "R12");
        ev_status();
        chk_state(1, 0, 0, "R3");
    endtask

    task automatic t_delay();
        @(negedge clk); delay_status = 1'b1;
        ev_setup(1'b0, 0, 1'b0);
        chk_state(1, 0, 0, "R10");
        ev_status();
        chk_state(1, 0, 0, "R10");
        delay_status = 1'b0; #1;
        check(int'(status_ack_req), 1, "R10", "released ack");
        ev_status();
        chk_state(1, 0, 0, "R10");
    endtask

    task automatic t_stall();
        ev_setup(1'b0, 40, 1'b0);
        ev_stall();
        chk_state(5, 1, 0, "R7");
        ev_in(1'b1, 1'b1);
        ev_out(3);
        ev_status();
        chk_state(5, 1, 0, "R8");
        ev_setup(1'b1, 4, 1'b0);
        chk_state(2, 0, 0, "R8");
        ev_stall();
        chk_state(5, 1, 0, "R7");
        ev_setup(1'b1, 0, 1'b0);
        chk_state(1, 0, 1, "R8");
        ev_stall();
        chk_state(5, 1, 0, "R7");
        ev_setup(1'b0, 0, 1'b0);
        ev_status();
    endtask

    task automatic t_priority();
        ev_setup(1'b0, 8, 1'b1);
        chk_state(3, 0, 0, "R9");
        ev_out(8);
        chk_state(1, 0, 1, "R6");
        ev_status();
    endtask

    task automatic t_buffer();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rsp_wr_en = 1'b1; rsp_wr_idx = IDX_W'(i); rsp_wr_data = 8'(8'hA0 + i);
        end
        for (int i = 6; i < 8; i++) begin
            @(negedge clk);
            rsp_wr_en = 1'b1; rsp_wr_idx = IDX_W'(i); rsp_wr_data = 8'h5C;
        end
        @(negedge clk); rsp_wr_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rsp_rd_idx = IDX_W'(i); #1;
            check(int'(rsp_rd_data), (i < 6) ? (8'hA0 + i) : 0, "R11", "buffer byte");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_in_transfer();
        t_out_short();
        t_out_exact();
        t_zero_len();
        t_delay();
        t_stall();
        t_priority();
        t_buffer();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule